// File: doc/BRIEF.md
# Linear Sweep Accumulator Controller

This block produces the tuning word for one channel of a digital synthesizer while that channel performs a linear sweep. The sweep moves between a lower limit and an upper limit. A direction input picks the way it moves: high climbs toward the upper limit by the up-step on every tick, and low descends toward the lower limit by the down-step. The ticks come from an external ramp-rate timer as single-cycle strobes. Between strobes the word does not change.

A two-bit kind field says what is being swept: amplitude, frequency or phase. The kind sets the active word width. Every input word is cut to that width, and so is the result. An optional no-dwell setting sends the word back to zero at the moment a climb reaches the upper limit, instead of parking there. Either step size may be changed during a sweep. When the sweep is switched off, the word sits at the lower limit.

Top module: `lin_sweep_ctrl`

## Requirements
- R1: `sweep_kind` sets the active width. 2'b01 selects amplitude with 10 bits. 2'b10 selects frequency with 32 bits. 2'b11 selects phase with 14 bits. 2'b00 means no sweep, and the width is then the full 32 bits.
- R2: The sweep is active only when `sweep_on` is 1 and `sweep_kind` is not 2'b00. In any clock cycle where it is inactive, the word loads the masked `lo_word` at the next edge. Reset clears the word to 0.
- R3: While the sweep is active, the word changes only at an edge where `step_stb` is 1. At every other edge it holds, whatever the other inputs do.
- R4: On a strobe with `dir_up` set to 1, the word becomes the old word plus the masked `up_step`. The carry out of 32 bits is kept for the comparison in R5.
- R5: When `no_dwell` is 0, a climbing step whose sum reaches or passes the masked `hi_word` produces exactly `hi_word`. Further climbing strobes keep it there.
- R6: When `no_dwell` is 1, a climbing step whose sum reaches or passes `hi_word` produces 0.
- R7: On a strobe with `dir_up` set to 0, the word becomes the old word minus the masked `dn_step`. If the word is below `lo_word` + `dn_step`, the result is exactly `lo_word`. That limit is computed without wrap.
- R8: A new value on `up_step` or `dn_step` is used from the next strobe onward.
- R9: All bits of `sweep_word` above the active width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| sweep_on | input | 1 | sweep enable |
| sweep_kind | input | 2 | sweep type / width select |
| no_dwell | input | 1 | return to zero at upper limit |
| dir_up | input | 1 | direction: 1 climb, 0 descend |
| step_stb | input | 1 | one-cycle ramp tick |
| lo_word | input | 32 | lower (start) limit |
| hi_word | input | 32 | upper (end) limit |
| up_step | input | 32 | climbing step size |
| dn_step | input | 32 | descending step size |
| sweep_word | output | 32 | current sweep word |

## Verification
The word is a single register that feeds the output through a mask. Any bad accumulator state therefore shows on `sweep_word` one edge after the strobe or idle cycle that caused it, and later steps do not hide it. A wrong clamp shows as overshoot or a wrap. The clearest sign is a carry past 32 bits near the top of the frequency range, or a borrow below zero at the lower limit. A wrong mask shows up as soon as the kind changes, as stray high bits on the very next load of the lower limit.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_AMP   = 2'b01,
    KIND_FREQ  = 2'b10,
    KIND_PHASE = 2'b11
  } sweep_kind_e;
endpackage

// File: rtl/lsw_width_sel.sv
module lsw_width_sel #(
  parameter int DW  = 32,
  parameter int AMW = 10,
  parameter int FQW = 32,
  parameter int PHW = 14
) (
  input  logic [1:0]    kind,
  input  logic          on,
  output logic [DW-1:0] mask,
  output logic          active
);
  import lsw_pkg::*;

  function automatic logic [DW-1:0] low_ones(input int n);
    return {DW{1'b1}} >> (DW - n);
  endfunction

  localparam logic [DW-1:0] AM_MASK = low_ones(AMW);
  localparam logic [DW-1:0] FQ_MASK = low_ones(FQW);
  localparam logic [DW-1:0] PH_MASK = low_ones(PHW);

  always_comb begin
    unique case (sweep_kind_e'(kind))
      KIND_AMP:   mask = AM_MASK;
      KIND_FREQ:  mask = FQ_MASK;
      KIND_PHASE: mask = PH_MASK;
      default:    mask = {DW{1'b1}};
    endcase
  end

  assign active = on && (sweep_kind_e'(kind) != KIND_NONE);
endmodule

// File: rtl/lsw_step_unit.sv
module lsw_step_unit #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] up,
  input  logic [DW-1:0] dn,
  input  logic          dir_up,
  input  logic          no_dwell,
  output logic [DW-1:0] nxt,
  output logic          hit_hi,
  output logic          hit_lo
);
  function automatic logic [DW:0] wide_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [DW:0] climb_sum;
  logic [DW:0] floor_lim;

  assign climb_sum = wide_add(acc, up);
  assign floor_lim = wide_add(lo, dn);
  assign hit_hi    = climb_sum >= {1'b0, hi};
  assign hit_lo    = {1'b0, acc} < floor_lim;

  always_comb begin
    if (dir_up) begin
      if (hit_hi) nxt = no_dwell ? '0 : hi;
      else        nxt = climb_sum[DW-1:0];
    end else begin
      if (hit_lo) nxt = lo;
      else        nxt = acc - dn;
    end
  end
endmodule

// File: rtl/lin_sweep_ctrl.sv
module lin_sweep_ctrl #(
  parameter int DW  = 32,
  parameter int AMW = 10,
  parameter int FQW = 32,
  parameter int PHW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sweep_on,
  input  logic [1:0]    sweep_kind,
  input  logic          no_dwell,
  input  logic          dir_up,
  input  logic          step_stb,
  input  logic [DW-1:0] lo_word,
  input  logic [DW-1:0] hi_word,
  input  logic [DW-1:0] up_step,
  input  logic [DW-1:0] dn_step,
  output logic [DW-1:0] sweep_word
);
  logic [DW-1:0] mask;
  logic          active;
  logic [DW-1:0] lo_m, hi_m, up_m, dn_m;
  logic [DW-1:0] acc_q, acc_nxt;
  logic          hit_hi, hit_lo;
  logic          step_fire;

  lsw_width_sel #(.DW(DW), .AMW(AMW), .FQW(FQW), .PHW(PHW)) u_wsel (
    .kind(sweep_kind), .on(sweep_on), .mask(mask), .active(active)
  );

  assign lo_m = lo_word & mask;
  assign hi_m = hi_word & mask;
  assign up_m = up_step & mask;
  assign dn_m = dn_step & mask;

  lsw_step_unit #(.DW(DW)) u_step (
    .acc(acc_q), .lo(lo_m), .hi(hi_m), .up(up_m), .dn(dn_m),
    .dir_up(dir_up), .no_dwell(no_dwell),
    .nxt(acc_nxt), .hit_hi(hit_hi), .hit_lo(hit_lo)
  );

  assign step_fire = active && step_stb;

  always_ff @(posedge clk) begin
    if (!rst_n)         acc_q <= '0;
    else if (!active)   acc_q <= lo_m;
    else if (step_fire) acc_q <= acc_nxt;
  end

  assign sweep_word = acc_q & mask;
endmodule

// File: rtl/lsw_chk.sv
module lsw_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          step_stb,
  input logic          dir_up,
  input logic          no_dwell,
  input logic          hit_hi,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] lo_m,
  input logic [DW-1:0] hi_m
);
  AST_IDLE_LOADS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> acc_q == $past(lo_m)); // R2
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !step_stb) |=> $stable(acc_q)); // R3
  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step_stb && dir_up) |=> acc_q <= $past(hi_m)); // R5
  AST_NODWELL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step_stb && dir_up && no_dwell && hit_hi) |=> acc_q == '0); // R6
  AST_NO_UNDERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step_stb && !dir_up) |=> acc_q >= $past(lo_m)); // R7
endmodule

bind lin_sweep_ctrl lsw_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .step_stb(step_stb),
  .dir_up(dir_up), .no_dwell(no_dwell), .hit_hi(hit_hi),
  .acc_q(acc_q), .lo_m(lo_m), .hi_m(hi_m)
);

// File: tb/sim_lin_sweep_ctrl.sv
module sim_lin_sweep_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on = 1'b0, nd = 1'b0, up = 1'b0, stb = 1'b0;
  logic [1:0] kind = 2'b10;
  logic [31:0] lo = '0, hi = '0, us = '0, ds = '0;
  logic [31:0] word;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  lin_sweep_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sweep_on(on), .sweep_kind(kind),
    .no_dwell(nd), .dir_up(up), .step_stb(stb),
    .lo_word(lo), .hi_word(hi), .up_step(us), .dn_step(ds),
    .sweep_word(word)
  );

  typedef struct packed {
    logic        on;
    logic [1:0]  kind;
    logic        nd;
    logic        up;
    logic        stb;
    logic [31:0] lo, hi, us, ds, exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 32'd100, 32'd400, 32'd120, 32'd50, 32'd100, 4'd2}, // R2 idle
    '{1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 32'd100, 32'd400, 32'd120, 32'd50, 32'd100, 4'd3}, // R3 no strobe
    '{1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 32'd100, 32'd400, 32'd120, 32'd50, 32'd220, 4'd4}, // R4
    '{1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 32'd100, 32'd400, 32'd120, 32'd50, 32'd220, 4'd3}, // R3
    '{1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 32'd100, 32'd400, 32'd120, 32'd50, 32'd340, 4'd4}, // R4
    '{1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 32'd100, 32'd400, 32'd120, 32'd50, 32'd400, 4'd5}, // R5 clamp
    '{1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 32'd100, 32'd400, 32'd120, 32'd50, 32'd400, 4'd5}, // R5 dwell
    '{1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 32'd100, 32'd400, 32'd120, 32'd50, 32'd350, 4'd7}, // R7
    '{1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 32'd100, 32'd400, 32'd120, 32'd200, 32'd150, 4'd8}, // R8 new down step
    '{1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 32'd100, 32'd400, 32'd120, 32'd200, 32'd100, 4'd7}, // R7 floor
    '{1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 32'd100, 32'd400, 32'd300, 32'd200, 32'd0, 4'd6}, // R6
    '{1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 32'd100, 32'd400, 32'd300, 32'd200, 32'd300, 4'd8}, // R8 new up step
    '{1'b0, 2'b10, 1'b1, 1'b1, 1'b1, 32'd100, 32'd400, 32'd300, 32'd200, 32'd100, 4'd2}, // R2
    '{1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 32'h12345, 32'hFFFFF3FF, 32'h10000064, 32'd10, 32'd837, 4'd9}, // R9 amp mask
    '{1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 32'h12345, 32'hFFFFF3FF, 32'h10000064, 32'd10, 32'd937, 4'd1}, // R1 amp
    '{1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 32'h12345, 32'hFFFFF3FF, 32'h10000064, 32'd10, 32'd1023, 4'd5}, // R5
    '{1'b0, 2'b11, 1'b0, 1'b1, 1'b1, 32'hFFFF0010, 32'h3000, 32'hABCD1000, 32'd10, 32'd16, 4'd9}, // R9 phase
    '{1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 32'hFFFF0010, 32'h3000, 32'hABCD1000, 32'd10, 32'd4112, 4'd1}, // R1 phase
    '{1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 32'hFFFF0010, 32'h3000, 32'hABCD1000, 32'd10, 32'd8208, 4'd4}, // R4
    '{1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 32'hFFFF0010, 32'h3000, 32'hABCD1000, 32'd10, 32'd12288, 4'd5}, // R5
    '{1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 32'hFFFF0010, 32'h3000, 32'hABCD1000, 32'd10, 32'hFFFF0010, 4'd2}, // R2 kind none
    '{1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 32'hFFFFFF00, 32'hFFFFFFF0, 32'h100, 32'hFFFFFFFF, 32'hFFFFFF00, 4'd2}, // R2
    '{1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 32'hFFFFFF00, 32'hFFFFFFF0, 32'h100, 32'hFFFFFFFF, 32'hFFFFFFF0, 4'd5}, // R5 carry
    '{1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 32'hFFFFFF00, 32'hFFFFFFF0, 32'h100, 32'hFFFFFFFF, 32'hFFFFFF00, 4'd7}  // R7 borrow
  };

  task automatic check(input string req, input logic [31:0] exp);
    total++;
    if (word !== exp) begin
      bad++;
      $display("FAIL %s: sweep_word=%h expected=%h", req, word, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    on = v.on; kind = v.kind; nd = v.nd; up = v.up; stb = v.stb;
    lo = v.lo; hi = v.hi; us = v.us; ds = v.ds;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset", 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VT[i]);
      @(negedge clk);
      check($sformatf("R%0d row %0d", VT[i].req, i), VT[i].exp);
    end
    // R3: no strobe, deltas and direction moving, word frozen
    on = 1'b1; kind = 2'b10; stb = 1'b0;
    for (int k = 0; k < 4; k++) begin
      up = k[0]; us = 32'd7 * k; ds = 32'd3 * k;
      @(negedge clk);
      check("R3 hold", 32'hFFFFFF00);
    end
    // R9: amplitude switch exposes no high bits
    on = 1'b0; kind = 2'b01; lo = 32'hFFFFFFFF;
    @(negedge clk);
    check("R9 mask", 32'h3FF);
    // R2: reset mid-sweep clears
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 reset", 32'd0);
    rst_n = 1'b1;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule